// File: doc/BRIEF.md
# Hypervisor debug access trap controller

This block keeps a 32-bit debug-control register owned by the hypervisor level. It decides, for each debug-related or performance-monitor access made from a lower privilege level, whether the access must be trapped to the hypervisor. It also decides whether a software debug exception raised at a lower level should be routed to the hypervisor instead of being taken locally. The instruction pipeline presents each access with its exception level, its security state and an access-class code, and gets the trap decision back in the same cycle.

Six bits of the register carry meaning. Bit 11 traps the debug ROM address class. Bit 10 traps the OS-related debug class, which covers OS lock, OS lock status, OS double lock and power/reset control. Bit 9 traps every other debug register. Bit 8 routes software debug exceptions to the hypervisor and also forces all debug traps. Bit 7 enables the counters reserved for the hypervisor or for Secure use. Bit 6 traps the performance-monitor class.

An external takeover input forces the three debug trap bits and the routing bit on. Another path also forces the three debug trap bits: bit 8 itself. Neither override changes the stored or read-back values. All other bit positions are reserved.

Top module: `hdt_ctrl`

## Requirements
- R1: Reads return zero in bits 31..12 and 5..0 whatever value was written.
- R2: A read strobe (`rd_en`) returns the stored bits 11..6 on `rd_data` in the following cycle. In any cycle that follows one without `rd_en`, `rd_data` is zero. Bit 7 stores and returns whatever is written.
- R3: A synchronous reset clears bits 11, 10, 9, 8 and 6. After reset, with `hyp_takeover` low, no access traps and no debug exception is routed. Bit 7 is not reset.
- R4: An access of class 0 (debug ROM address) traps when bit 11 is set.
- R5: An access of class 1 (OS-related debug) traps when bit 10 is set.
- R6: An access of class 2 (other debug) traps when bit 9 is set. Bits 11 and 10 have no effect on class 2.
- R7: When `hyp_takeover` is 1 or bit 8 is 1, classes 0, 1 and 2 trap whatever bits 11..9 hold. The read-back value still shows the bits as written.
- R8: An access of class 3 (performance monitor) traps only when bit 6 is set. `hyp_takeover` and bit 8 have no effect on class 3.
- R9: `route_o` is 1 exactly when `swdbg_req` is 1, the requester is Non-secure (`acc_ns`=1) at level 0 or 1, and either bit 8 or `hyp_takeover` is 1.
- R10: No trap is raised when `acc_vld` is 0, when the access is Secure (`acc_ns`=0), or when the access comes from level 2 or 3.
- R11: `trap_o` is valid in the same cycle as `acc_vld`. An access in the same cycle as a write sees the old register value. An access in the next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Read-back value, one cycle after `rd_en` |
| acc_vld | input | 1 | Access present this cycle |
| acc_el | input | 2 | Exception level of the access (0..3) |
| acc_ns | input | 1 | 1 = Non-secure access |
| acc_cls | input | 2 | Access class: 0 ROM address, 1 OS-related, 2 other debug, 3 performance monitor |
| hyp_takeover | input | 1 | Hypervisor takeover control, forces debug traps and routing |
| swdbg_req | input | 1 | Software debug exception request |
| trap_o | output | 1 | Trap the access to the hypervisor level |
| route_o | output | 1 | Route the debug exception to the hypervisor level |

## Verification
The assertions assume that every input is a defined 0 or 1 at each clock edge, and that `acc_el` only takes the four level codes. The override and reset properties also rely on `hyp_takeover` being stable during the cycle in which it is sampled. They do not depend on how reads and writes overlap with accesses.

The stimulus drives every input at the falling edge from a single task at a time, so the sampled values never change around the rising edge. The stimulus covers all four classes, both security states and all four levels. It also includes a write that overlaps an access, to reach the ordering corner.

// File: rtl/hdt_pkg.sv
package hdt_pkg;
  localparam int POS_ROM   = 11;
  localparam int POS_OS    = 10;
  localparam int POS_DBG   = 9;
  localparam int POS_ROUTE = 8;
  localparam int POS_HPM   = 7;
  localparam int POS_PM    = 6;
  localparam int NCLS      = 4;

  typedef enum logic [1:0] {
    CLS_ROM = 2'd0,
    CLS_OS  = 2'd1,
    CLS_DBG = 2'd2,
    CLS_PMU = 2'd3
  } acc_cls_e;

  typedef struct packed {
    logic rom;
    logic os;
    logic dbg;
    logic route;
    logic hpm;
    logic pm;
  } ctl_t;
endpackage

// File: rtl/hdt_regs.sv
module hdt_regs
  import hdt_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output ctl_t             ctl
);
  ctl_t             ctl_q;
  logic             hpm_q;
  logic [REG_W-1:0] image;

  // trap and routing bits: cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q.rom   <= 1'b0;
      ctl_q.os    <= 1'b0;
      ctl_q.dbg   <= 1'b0;
      ctl_q.route <= 1'b0;
      ctl_q.pm    <= 1'b0;
    end else if (wr_en) begin
      ctl_q.rom   <= wr_data[POS_ROM];
      ctl_q.os    <= wr_data[POS_OS];
      ctl_q.dbg   <= wr_data[POS_DBG];
      ctl_q.route <= wr_data[POS_ROUTE];
      ctl_q.pm    <= wr_data[POS_PM];
    end
  end

  // counter enable bit: no reset value
  always_ff @(posedge clk) begin
    if (wr_en) hpm_q <= wr_data[POS_HPM];
  end

  always_comb begin
    ctl       = ctl_q;
    ctl.hpm   = hpm_q;
    image     = '0;
    image[POS_ROM]   = ctl_q.rom;
    image[POS_OS]    = ctl_q.os;
    image[POS_DBG]   = ctl_q.dbg;
    image[POS_ROUTE] = ctl_q.route;
    image[POS_HPM]   = hpm_q;
    image[POS_PM]    = ctl_q.pm;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= image;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/hdt_decide.sv
module hdt_decide
  import hdt_pkg::*;
#(
  parameter int EL_W   = 2,
  parameter int HYP_EL = 2
) (
  input  ctl_t            ctl,
  input  logic            acc_vld,
  input  logic [EL_W-1:0] acc_el,
  input  logic            acc_ns,
  input  logic [1:0]      acc_cls,
  input  logic            hyp_takeover,
  input  logic            swdbg_req,
  output logic            trap_o,
  output logic            route_o
);
  localparam logic [EL_W-1:0] HYP_LVL = EL_W'(HYP_EL);

  logic            lower_ns;
  logic            force_dbg;
  logic [NCLS-1:0] cls_hit;
  logic [NCLS-1:0] cls_sel;

  assign lower_ns  = acc_ns && (acc_el < HYP_LVL);
  assign force_dbg = hyp_takeover || ctl.route;

  always_comb begin
    cls_hit          = '0;
    cls_hit[CLS_ROM] = ctl.rom || force_dbg;
    cls_hit[CLS_OS]  = ctl.os  || force_dbg;
    cls_hit[CLS_DBG] = ctl.dbg || force_dbg;
    cls_hit[CLS_PMU] = ctl.pm;
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_sel
    assign cls_sel[g] = (acc_cls == 2'(g)) && cls_hit[g];
  end

  assign trap_o  = acc_vld && lower_ns && (|cls_sel);
  assign route_o = swdbg_req && lower_ns && force_dbg;
endmodule

// File: rtl/hdt_ctrl.sv
module hdt_ctrl
  import hdt_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int EL_W   = 2,
  parameter int HYP_EL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             acc_vld,
  input  logic [EL_W-1:0]  acc_el,
  input  logic             acc_ns,
  input  logic [1:0]       acc_cls,
  input  logic             hyp_takeover,
  input  logic             swdbg_req,
  output logic             trap_o,
  output logic             route_o
);
  ctl_t ctl;

  hdt_regs #(.REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .ctl     (ctl)
  );

  hdt_decide #(.EL_W(EL_W), .HYP_EL(HYP_EL)) u_decide (
    .ctl          (ctl),
    .acc_vld      (acc_vld),
    .acc_el       (acc_el),
    .acc_ns       (acc_ns),
    .acc_cls      (acc_cls),
    .hyp_takeover (hyp_takeover),
    .swdbg_req    (swdbg_req),
    .trap_o       (trap_o),
    .route_o      (route_o)
  );
endmodule

// File: rtl/hdt_ctrl_chk.sv
module hdt_ctrl_chk #(
  parameter int REG_W  = 32,
  parameter int EL_W   = 2,
  parameter int HYP_EL = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             rd_en,
  input logic [REG_W-1:0] rd_data,
  input logic             acc_vld,
  input logic [EL_W-1:0]  acc_el,
  input logic             acc_ns,
  input logic [1:0]       acc_cls,
  input logic             hyp_takeover,
  input logic             swdbg_req,
  input logic             trap_o,
  input logic             route_o
);
  localparam logic [EL_W-1:0] HYP_LVL = EL_W'(HYP_EL);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data[REG_W-1:12] == '0) && (rd_data[5:0] == 6'd0)); // R1

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0)); // R2

  AST_NO_TRAP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!acc_ns || acc_el >= HYP_LVL) |-> !trap_o); // R10

  AST_TRAP_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> acc_vld); // R10

  AST_ROUTE_GATED: assert property (@(posedge clk) disable iff (rst)
    route_o |-> (swdbg_req && acc_ns && acc_el < HYP_LVL)); // R9

  AST_TAKEOVER_FORCES: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && acc_ns && acc_el < HYP_LVL && hyp_takeover && acc_cls != 2'd3)
      |-> trap_o); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !hyp_takeover) |-> (!trap_o && !route_o)); // R3

  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && $past(wr_data[11]) && acc_vld && acc_ns
      && acc_el < HYP_LVL && acc_cls == 2'd0) |-> trap_o); // R11
endmodule

bind hdt_ctrl hdt_ctrl_chk u_chk (.*);

// File: tb/hdt_ctrl_tb.sv
module hdt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        acc_vld = 1'b0;
  logic [1:0]  acc_el = '0;
  logic        acc_ns = 1'b0;
  logic [1:0]  acc_cls = '0;
  logic        hyp_takeover = 1'b0;
  logic        swdbg_req = 1'b0;
  logic        trap_o;
  logic        route_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;

  typedef struct {
    logic  trap;
    logic  route;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  hdt_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .acc_vld(acc_vld), .acc_el(acc_el),
    .acc_ns(acc_ns), .acc_cls(acc_cls), .hyp_takeover(hyp_takeover),
    .swdbg_req(swdbg_req), .trap_o(trap_o), .route_o(route_o)
  );

  function automatic logic exp_trap(logic [31:0] m, logic v, logic [1:0] el,
                                    logic ns, logic [1:0] cls, logic tk);
    logic f;
    f = tk | m[8];
    if (!v || !ns || el >= 2'd2) return 1'b0;
    case (cls)
      2'd0:    return m[11] | f;
      2'd1:    return m[10] | f;
      2'd2:    return m[9]  | f;
      default: return m[6];
    endcase
  endfunction

  task automatic access(logic v, logic [1:0] el, logic ns, logic [1:0] cls,
                        logic tk, logic sdx, string tag);
    exp_t e;
    @(negedge clk);
    acc_vld = v; acc_el = el; acc_ns = ns; acc_cls = cls;
    hyp_takeover = tk; swdbg_req = sdx;
    e.trap  = exp_trap(model, v, el, ns, cls, tk);
    e.route = sdx && ns && (el < 2'd2) && (model[8] || tk);
    e.tag   = tag;
    sbq.push_back(e);
  endtask

  task automatic write_reg(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model = d & 32'h0000_0FC0;
  endtask

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(logic [31:0] mask, string tag);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data & mask, model & mask, tag);
    @(negedge clk);
    check(rd_data, 32'h0, "R2 idle read");
  endtask

  task automatic sweep_classes(logic tk, string tag);
    for (int c = 0; c < 4; c++) access(1'b1, 2'd1, 1'b1, 2'(c), tk, 1'b0, tag);
  endtask

  // monitor: compares combinational outputs mid-cycle
  always begin
    @(negedge clk);
    #3;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (trap_o !== e.trap || route_o !== e.route) begin
        errors++;
        $display("FAIL %s actual trap=%b route=%b expected trap=%b route=%b",
                 e.tag, trap_o, route_o, e.trap, e.route);
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 reset state, bit 7 masked
    read_reg(32'hFFFF_FF7F, "R3 reset read");
    sweep_classes(1'b0, "R3 no trap after reset");
    access(1'b1, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1, "R3 no route after reset");
    // R1 R2 full write
    write_reg(32'hFFFF_FFFF);
    read_reg(32'hFFFF_FFFF, "R1 R2 all-ones readback");
    sweep_classes(1'b0, "R4 R5 R6 R8 all set");
    // single-bit patterns
    write_reg(32'h0000_0800);
    sweep_classes(1'b0, "R4 rom bit only");
    write_reg(32'h0000_0400);
    sweep_classes(1'b0, "R5 os bit only");
    write_reg(32'h0000_0A00 ^ 32'h0000_0800 | 32'h0000_0C00 & 32'h0);
    sweep_classes(1'b0, "R6 dbg bit only");
    write_reg(32'h0000_0040);
    sweep_classes(1'b0, "R8 pm bit only");
    write_reg(32'h0000_0080);
    read_reg(32'hFFFF_FFFF, "R2 bit7 readback");
    sweep_classes(1'b0, "R8 bit7 traps nothing");
    // R7 bit 8 override
    write_reg(32'h0000_0100);
    read_reg(32'hFFFF_FFFF, "R7 override readback");
    sweep_classes(1'b0, "R7 bit8 forces debug");
    access(1'b1, 2'd0, 1'b1, 2'd2, 1'b0, 1'b1, "R9 route by bit8");
    // R7 takeover input
    write_reg(32'h0000_0000);
    sweep_classes(1'b1, "R7 takeover forces debug");
    read_reg(32'hFFFF_FFFF, "R7 takeover readback");
    access(1'b1, 2'd1, 1'b1, 2'd3, 1'b1, 1'b1, "R9 route by takeover");
    access(1'b0, 2'd1, 1'b1, 2'd0, 1'b0, 1'b1, "R9 no route");
    access(1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1, "R9 secure no route");
    // R10 gating
    write_reg(32'h0000_0FC0);
    access(1'b1, 2'd2, 1'b1, 2'd0, 1'b1, 1'b1, "R10 level2");
    access(1'b1, 2'd3, 1'b1, 2'd3, 1'b0, 1'b0, "R10 level3");
    access(1'b1, 2'd1, 1'b0, 2'd1, 1'b1, 1'b0, "R10 secure level1");
    access(1'b1, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, "R10 secure level0");
    access(1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, "R10 no valid");
    access(1'b1, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0, "R8 level0 pm");
    // R11 same-cycle write sees old value
    write_reg(32'h0000_0000);
    access(1'b1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, "R11 before write");
    wr_en = 1'b1; wr_data = 32'h0000_0800;
    @(negedge clk);
    wr_en = 1'b0;
    model = 32'h0000_0800;
    access(1'b1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, "R11 after write");
    access(1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R10 idle");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule